// File: doc/BRIEF.md
# Ranged Burst Transfer Sequencer with Checksum

This block is a host-side I/O master. It takes a request made of a direction, a 16-bit start port, a byte count and a checksum seed. It carries the request out as a run of single-byte I/O cycles, and it adds every byte it moves into an 8-bit running sum. For a write, the bytes come from an input stream. For a read, the bytes go out on an output stream as the slave returns them.

Most ports are reached directly, one cycle per byte, at the start port plus the byte index. Ports that fall in a configured window are reached through an indirect register window instead. The sequencer first writes a two-byte window address. It then moves data through four data-byte registers that the far side increments by itself. A start that is not aligned to four bytes begins partway into the first group. A length that is not a multiple of four ends partway into the last group.

Top module: `burst_sequencer`

## Requirements
- R1: A request whose start port lies between WIN_LO (default 0x800) and WIN_HI (default 0x9FF), both ends included, takes the window path. Any other request is issued directly: byte i goes to port start+i.
- R2: On the window path, with offset = start - WIN_LO, the first I/O cycle writes ((offset & 0xFC) | 3) to port WIN_LO+2. The second writes ((offset >> 8) & 0x7F) to port WIN_LO+3.
- R3: On the window path, the first data cycle addresses port WIN_LO+4+(start & 3). Each later data cycle addresses the next data port. After WIN_LO+7 it wraps to WIN_LO+4, and the address is not written again.
- R4: Exactly `length` data cycles are issued, even when this ends inside a 4-byte group. The `done` output pulses for one clock in the cycle after the final byte is acknowledged.
- R5: A zero-length request issues no I/O cycle. It pulses `done` in the cycle after acceptance, with `done_csum` equal to the seed.
- R6: `done_csum` equals the seed plus every data byte transferred, modulo 256. This holds for reads and for writes. Window address bytes are not included.
- R7: `req_ready` is high only while no transfer is active. It is low from the cycle after a non-zero-length request is accepted until that transfer completes.
- R8: Each I/O cycle keeps its address, direction and write data until `io_ack`, and each acknowledged data cycle moves exactly one byte. On a write, `wr_ready` marks the consumed byte. On a read, `rd_valid` presents the returned byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted (idle) |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_port | input | 16 | Start port |
| req_len | input | LEN_W | Byte count |
| req_csum | input | 8 | Checksum seed |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Write stream byte consumed |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| io_req | output | 1 | I/O cycle requested |
| io_write | output | 1 | I/O cycle is a write |
| io_addr | output | 16 | I/O port address |
| io_wdata | output | 8 | I/O write byte |
| io_rdata | input | 8 | I/O read byte |
| io_ack | input | 1 | Slave completes the current cycle |
| done | output | 1 | Transfer completed (one-clock pulse) |
| done_csum | output | 8 | Final checksum, valid with done |

## Verification
The bench builds the block with its defaults: LEN_W of 8, and a window from 0x800 to 0x9FF. With these values, start ports on both sides of each window edge (0x7FF, 0x800, 0x9FF, 0xA00) can be reached. The offset 0x1FF at the top edge sets every low address bit and a non-zero high address byte. Lengths up to nine cross the data-lane wrap more than once. A slave that acknowledges only on alternate clocks exercises the hold-until-acknowledge behaviour on both address and data cycles.

// File: rtl/burst_sequencer.sv
module burst_sequencer #(
  parameter int          LEN_W  = 8,
  parameter logic [15:0] WIN_LO = 16'h0800,
  parameter logic [15:0] WIN_HI = 16'h09FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [15:0]      req_port,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       req_csum,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             io_req,
  output logic             io_write,
  output logic [15:0]      io_addr,
  output logic [7:0]       io_wdata,
  input  logic [7:0]       io_rdata,
  input  logic             io_ack,
  output logic             done,
  output logic [7:0]       done_csum
);
  typedef enum logic [1:0] {S_IDLE, S_A0, S_A1, S_DAT} st_t;

  st_t              st;
  logic             wr_q, win_q, done_q;
  logic [15:0]      port_q;
  logic [LEN_W-1:0] left_q;
  logic [1:0]       lane_q;
  logic [7:0]       sum_q, dsum_q;

  wire [15:0] off    = port_q - WIN_LO;
  wire        accept = req_valid && req_ready;
  wire        in_win = (req_port >= WIN_LO) && (req_port <= WIN_HI);
  wire        xfer   = (st == S_DAT) && io_req && io_ack;
  wire [7:0]  beat   = wr_q ? wr_data : io_rdata;

  assign req_ready = (st == S_IDLE);
  assign io_req    = (st != S_IDLE) && ((st != S_DAT) || !wr_q || wr_valid);
  assign io_write  = (st != S_DAT) || wr_q;
  assign io_addr   = (st == S_A0) ? WIN_LO + 16'd2 :
                     (st == S_A1) ? WIN_LO + 16'd3 :
                     win_q        ? WIN_LO + 16'd4 + {14'd0, lane_q} : port_q;
  assign io_wdata  = (st == S_A0) ? {off[7:2], 2'b11} :
                     (st == S_A1) ? {1'b0, off[14:8]} : wr_data;
  assign wr_ready  = xfer && wr_q;
  assign rd_valid  = xfer && !wr_q;
  assign rd_data   = io_rdata;
  assign done      = done_q;
  assign done_csum = dsum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wr_q <= 1'b0; win_q <= 1'b0; done_q <= 1'b0;
      port_q <= '0; left_q <= '0; lane_q <= '0; sum_q <= '0; dsum_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          wr_q   <= req_write;
          win_q  <= in_win;
          port_q <= req_port;
          left_q <= req_len;
          lane_q <= req_port[1:0];
          sum_q  <= req_csum;
          if (req_len == '0) begin
            done_q <= 1'b1;
            dsum_q <= req_csum;
          end else begin
            st <= in_win ? S_A0 : S_DAT;
          end
        end
        S_A0: if (io_ack) st <= S_A1;
        S_A1: if (io_ack) st <= S_DAT;
        S_DAT: if (xfer) begin
          sum_q  <= sum_q + beat;
          port_q <= port_q + 16'd1;
          lane_q <= lane_q + 2'd1;
          left_q <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            dsum_q <= sum_q + beat;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  win_addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_len != '0 && in_win) |=> (io_req && io_write && io_addr == WIN_LO + 16'd2));

  // R3
  lane_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && win_q && io_addr == WIN_LO + 16'd7 && left_q != LEN_W'(1)) |=> (io_addr == WIN_LO + 16'd4));

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_len == '0) |=> (done && !io_req && done_csum == $past(req_csum)));

  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> !req_ready);

  // R8
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_ack) |=> (!io_req || (io_addr == $past(io_addr) && io_write == $past(io_write))));
endmodule

// File: tb/burst_sequencer_test.sv
module burst_sequencer_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_port = '0;
  logic [7:0]  req_len = '0, req_csum = '0;
  logic [7:0]  wr_data;
  logic        wr_valid = 1'b1;
  logic        req_ready, wr_ready, rd_valid, io_req, io_write, done;
  logic [7:0]  rd_data, io_wdata, io_rdata, done_csum;
  logic [15:0] io_addr;
  logic        io_ack = 1'b0;
  logic        wait_mode = 1'b0;

  int total = 0, bad = 0;
  logic [15:0] la [0:63];
  logic        lw [0:63];
  logic [7:0]  ld [0:63];
  logic [7:0]  wbuf [0:63];
  logic [7:0]  rgot [0:63];
  int nlog = 0, nrd = 0, ndone = 0, widx = 0;
  logic [7:0] last_dsum = '0;

  always #2 clk = ~clk;

  burst_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_port(req_port), .req_len(req_len), .req_csum(req_csum),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .io_req(io_req), .io_write(io_write),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
    .done(done), .done_csum(done_csum));

  assign io_rdata = io_addr[7:0] ^ 8'hA5;
  assign wr_data  = wbuf[widx[5:0]];

  always @(negedge clk) begin
    io_ack = wait_mode ? ~io_ack : 1'b1;
    if (rst_n && io_req && io_ack && nlog < 64) begin
      la[nlog] = io_addr;
      lw[nlog] = io_write;
      ld[nlog] = io_write ? io_wdata : io_rdata;
      nlog++;
    end
  end

  always @(posedge clk) begin
    if (wr_valid && wr_ready) widx <= widx + 1;
    if (rd_valid && nrd < 64) begin rgot[nrd] <= rd_data; nrd <= nrd + 1; end
    if (done) begin ndone <= ndone + 1; last_dsum <= done_csum; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit w, input logic [15:0] p, input int len, input logic [7:0] seed, input string req);
    logic [15:0] ea [0:63];
    logic        ew [0:63];
    logic [7:0]  ed [0:63];
    int n = 0, d0, t, badi;
    logic [7:0] sum;
    logic [15:0] off;
    bit win;
    for (int i = 0; i < 64; i++) wbuf[i] = 8'(i * 37) ^ p[7:0] ^ seed;
    @(negedge clk);
    nlog = 0; nrd = 0; widx = 0; d0 = ndone;
    req_write = w; req_port = p; req_len = 8'(len); req_csum = seed; req_valid = 1'b1;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 1'b0;
    // R7: busy after accepting a non-empty request
    if (len > 0) chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
    t = 0;
    while (ndone == d0 && t < 500) begin @(negedge clk); t++; end
    @(negedge clk);
    // expected trace from R1, R2, R3, R6
    win = (p >= 16'h0800) && (p <= 16'h09FF);
    off = p - 16'h0800;
    sum = seed;
    if (win && len > 0) begin
      ea[0] = 16'h0802; ew[0] = 1'b1; ed[0] = {off[7:2], 2'b11};
      ea[1] = 16'h0803; ew[1] = 1'b1; ed[1] = {1'b0, off[14:8]};
      n = 2;
    end
    for (int i = 0; i < len; i++) begin
      ea[n] = win ? 16'h0804 + 16'((p[1:0] + i) % 4) : p + 16'(i);
      ew[n] = w;
      ed[n] = w ? wbuf[i] : (ea[n][7:0] ^ 8'hA5);
      sum = sum + ed[n];
      n++;
    end
    chk(ndone == d0 + 1, "R4", {req, " done pulses"}, ndone - d0, 1);
    chk(nlog == n, "R4", {req, " io cycle count"}, nlog, n);
    badi = -1;
    for (int i = 0; i < n && i < nlog; i++)
      if (badi < 0 && (la[i] !== ea[i] || lw[i] !== ew[i] || ld[i] !== ed[i])) badi = i;
    if (badi >= 0)
      chk(1'b0, req, "io trace addr/data", {la[badi], ld[badi]}, {ea[badi], ed[badi]});
    else
      chk(1'b1, req, "io trace", 0, 0);
    chk(last_dsum == sum, "R6", {req, " checksum"}, last_dsum, sum);
    if (!w) begin
      badi = -1;
      for (int i = 0; i < len && i < 64; i++)
        if (badi < 0 && rgot[i] !== (ea[n - len + i][7:0] ^ 8'hA5)) badi = i;
      chk(nrd == len && badi < 0, "R8", {req, " read stream"}, nrd, len);
    end else begin
      chk(widx == len, "R8", {req, " write bytes consumed"}, widx, len);
    end
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R7", "reset ready", req_ready, 1);
    chk(io_req == 1'b0, "R7", "reset io_req", io_req, 0);
    chk(done == 1'b0, "R4", "reset done", done, 0);
  endtask

  task automatic t_direct;
    run(1'b1, 16'h0060, 5, 8'h11, "R1 direct write");
    run(1'b0, 16'h07FF, 3, 8'h22, "R1 below window read");
    run(1'b0, 16'h0A00, 2, 8'h33, "R1 above window read");
  endtask

  task automatic t_window;
    run(1'b1, 16'h0800, 4, 8'h44, "R2 aligned window write");
    run(1'b0, 16'h09FF, 6, 8'hF0, "R3 top edge misaligned read");
    run(1'b1, 16'h0905, 2, 8'h00, "R4 partial group write");
  endtask

  task automatic t_zero;
    run(1'b1, 16'h0810, 0, 8'h5C, "R5 zero length");
    chk(nlog == 0, "R5", "no io cycles", nlog, 0);
  endtask

  task automatic t_wait;
    wait_mode = 1'b1;
    run(1'b1, 16'h0812, 9, 8'h7E, "R8 waited window write");
    run(1'b0, 16'h0123, 4, 8'h01, "R8 waited direct read");
    wait_mode = 1'b0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_window();
    t_zero();
    t_wait();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule